// File: doc/BRIEF.md
# I2C Slave Address Classifier

This block sits next to the receive shift register of an I2C slave and decides what the first byte after a START condition means. It counts the falling SCL strobes of the address phase. On the eighth strobe it compares the received byte with a programmable local address. In the same step it checks the byte against the reserved extension-code classes: general call, start byte, CBUS, the other-bus-format class and 10-bit address headers.

When the byte is either a match or an extension code, the block raises a coincidence flag and/or an extension flag, reports a decoded class, and emits a one-cycle interrupt pulse. A byte that is neither leaves the block idle until the next START. A software release command makes the block leave the current transfer.

A separate comparator checks, during transmission, that every bit the slave drives matches the level sampled back from SDA. START/STOP detection and the byte capture happen elsewhere. Their results arrive here as single-cycle strobes and a byte value.

Top module: `i2c_addr_detect`

## Requirements
- R1: After reset, coinFlag, extFlag, irqPulse and txErr are 0, extType is 0 (none), engaged is 0 and localAddr is 0.
- R2: On the eighth sclFall strobe after startDet, coinFlag is set when rxByte[7:1] equals localAddr.
- R3: On that same strobe, extFlag is set when rxByte[7:4] is 4'b0000 or 4'b1111.
- R4: extType is decoded from a = rxByte[7:1] and rw = rxByte[0]. The encodings are:
  - 0 for none.
  - 1 for general call (a=0000000, rw=0).
  - 2 for start byte (a=0000000, rw=1).
  - 3 for CBUS (a=0000001).
  - 4 for other bus format (a=0000010).
  - 5 for a 10-bit header (a=11110xx).
  - 6 for any other extension code.
- R5: irqPulse is high for exactly one clock cycle, in the cycle after the eighth sclFall strobe is sampled, and only when coinFlag or extFlag is set by that byte. Earlier strobes give no pulse.
- R6: A byte that is neither a match nor an extension code gives no pulse, leaves the flags at 0, and drops engaged to 0.
- R7: localAddr changes only when addrWe is high. Receiving an extension code never alters it.
- R8: When localAddr holds a 10-bit header 11110xx and the same header is received, coinFlag and extFlag are both set and extType is 5.
- R9: A startDet or stopDet strobe clears coinFlag, extFlag, extType and txErr in the following cycle.
- R10: A relCmd strobe drops engaged to 0. Later sclFall strobes then produce no pulse and no flag update until the next startDet.
- R11: When txActive is high and an sclRise strobe sees txBit differ from sdaIn, txErr is set in the next cycle and holds until START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startDet | input | 1 | START condition strobe |
| stopDet | input | 1 | STOP condition strobe |
| sclFall | input | 1 | Falling SCL edge strobe |
| sclRise | input | 1 | Rising SCL edge strobe |
| rxByte | input | 8 | Received address byte, valid at the eighth falling edge |
| addrWe | input | 1 | Local address write enable |
| addrWd | input | 7 | Local address write data |
| relCmd | input | 1 | Software release strobe |
| txActive | input | 1 | Slave is driving SDA |
| txBit | input | 1 | Bit being driven |
| sdaIn | input | 1 | Sampled SDA level |
| localAddr | output | 7 | Stored local address |
| engaged | output | 1 | Block is within an address phase or a claimed transfer |
| coinFlag | output | 1 | Address coincidence flag |
| extFlag | output | 1 | Extension-code flag |
| extType | output | 3 | Decoded extension class |
| irqPulse | output | 1 | Address-phase interrupt pulse |
| txErr | output | 1 | Transmit bit-error flag |

## Verification
The classifier is given one address byte per class:
- A plain match, and a near miss that differs in one address bit.
- General call and start byte, which differ only in the R/W bit.
- CBUS in both R/W polarities, and the other-bus-format class.
- A matching and a non-matching 10-bit header.
- Two reserved patterns that fall outside the named classes.

Each pattern separates the match path from the extension path and shows that the class decoding uses the R/W bit only where it must. Further sequences place a release or a STOP inside the address phase, which shows that the pulse and the flags depend on the block being engaged. A driven-versus-sampled mismatch in the middle of a bit train shows that the error flag is sticky and is cleared by START.

// File: rtl/addr_detect_pkg.sv
package addr_detect_pkg;

  localparam int ADDR_W = 7;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int BITS_PER_ADDR = 8;
  localparam int CNT_W = $clog2(BITS_PER_ADDR);

  typedef enum logic [2:0] {
    EXT_NONE     = 3'd0,
    EXT_GCALL    = 3'd1,
    EXT_STARTB   = 3'd2,
    EXT_CBUS     = 3'd3,
    EXT_OTHERBUS = 3'd4,
    EXT_TENBIT   = 3'd5,
    EXT_RSVD     = 3'd6
  } extType_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_HELD = 2'd2
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFlags;
    logic capture;
  } ctrlStrobe_t;

endpackage

// File: rtl/addr_detect_dp.sv
module addr_detect_dp
  import addr_detect_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              addrWe,
  input  logic [ADDR_W-1:0] addrWd,
  input  logic              txActive,
  input  logic              txBit,
  input  logic              sdaIn,
  input  logic              sclRise,
  output logic              matchHit,
  output logic              extHit,
  output logic [ADDR_W-1:0] localAddr,
  output logic              coinFlag,
  output logic              extFlag,
  output logic [2:0]        extType,
  output logic              txErr
);

  logic [ADDR_W-1:0] rxAddr;
  logic              rxRw;
  extType_e          typeNext;

  assign rxAddr = rxByte[BYTE_W-1:1];
  assign rxRw   = rxByte[0];

  // local address register: only a software write alters it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) localAddr <= '0;
    else if (addrWe) localAddr <= addrWd;
  end

  // comparison and classification
  assign matchHit = (rxAddr == localAddr);
  assign extHit   = (rxByte[BYTE_W-1 -: 4] == 4'b0000) ||
                    (rxByte[BYTE_W-1 -: 4] == 4'b1111);

  always_comb begin
    typeNext = EXT_NONE;
    if (extHit) begin
      if (rxAddr == 7'b0000000)          typeNext = rxRw ? EXT_STARTB : EXT_GCALL;
      else if (rxAddr == 7'b0000001)     typeNext = EXT_CBUS;
      else if (rxAddr == 7'b0000010)     typeNext = EXT_OTHERBUS;
      else if (rxAddr[6:2] == 5'b11110)  typeNext = EXT_TENBIT;
      else                               typeNext = EXT_RSVD;
    end
  end

  // flag registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coinFlag <= 1'b0;
      extFlag  <= 1'b0;
      extType  <= EXT_NONE;
    end else if (strobes.clrFlags) begin
      coinFlag <= 1'b0;
      extFlag  <= 1'b0;
      extType  <= EXT_NONE;
    end else if (strobes.capture) begin
      coinFlag <= matchHit;
      extFlag  <= extHit;
      extType  <= typeNext;
    end
  end

  // transmit bit comparator, sticky until START/STOP
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) txErr <= 1'b0;
    else if (strobes.clrFlags) txErr <= 1'b0;
    else if (txActive && sclRise && (txBit != sdaIn)) txErr <= 1'b1;
  end

endmodule

// File: rtl/addr_detect_ctrl.sv
module addr_detect_ctrl
  import addr_detect_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startDet,
  input  logic        stopDet,
  input  logic        sclFall,
  input  logic        relCmd,
  input  logic        matchHit,
  input  logic        extHit,
  output ctrlStrobe_t strobes,
  output logic        engaged,
  output logic        irqPulse
);

  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS_PER_ADDR - 1);

  phase_e           phase;
  logic [CNT_W-1:0] bitCnt;
  logic             eighthFall;
  logic             hit;

  assign eighthFall = (phase == ST_ADDR) && sclFall && (bitCnt == LAST_BIT) &&
                      !startDet && !stopDet && !relCmd;
  assign hit        = matchHit || extHit;

  assign strobes.clrFlags = startDet || stopDet;
  assign strobes.capture  = eighthFall;
  assign engaged          = (phase != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= ST_IDLE;
      bitCnt   <= '0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= 1'b0;
      if (startDet) begin
        phase  <= ST_ADDR;
        bitCnt <= '0;
      end else if (stopDet || relCmd) begin
        phase  <= ST_IDLE;
        bitCnt <= '0;
      end else if (eighthFall) begin
        bitCnt   <= '0;
        irqPulse <= hit;
        phase    <= hit ? ST_HELD : ST_IDLE;
      end else if ((phase == ST_ADDR) && sclFall) begin
        bitCnt <= bitCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/i2c_addr_detect.sv
module i2c_addr_detect
  import addr_detect_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sclFall,
  input  logic              sclRise,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              addrWe,
  input  logic [ADDR_W-1:0] addrWd,
  input  logic              relCmd,
  input  logic              txActive,
  input  logic              txBit,
  input  logic              sdaIn,
  output logic [ADDR_W-1:0] localAddr,
  output logic              engaged,
  output logic              coinFlag,
  output logic              extFlag,
  output logic [2:0]        extType,
  output logic              irqPulse,
  output logic              txErr
);

  ctrlStrobe_t strobes;
  logic        matchHit;
  logic        extHit;

  addr_detect_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sclFall  (sclFall),
    .relCmd   (relCmd),
    .matchHit (matchHit),
    .extHit   (extHit),
    .strobes  (strobes),
    .engaged  (engaged),
    .irqPulse (irqPulse)
  );

  addr_detect_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .rxByte    (rxByte),
    .addrWe    (addrWe),
    .addrWd    (addrWd),
    .txActive  (txActive),
    .txBit     (txBit),
    .sdaIn     (sdaIn),
    .sclRise   (sclRise),
    .matchHit  (matchHit),
    .extHit    (extHit),
    .localAddr (localAddr),
    .coinFlag  (coinFlag),
    .extFlag   (extFlag),
    .extType   (extType),
    .txErr     (txErr)
  );

endmodule

// File: rtl/i2c_addr_detect_chk.sv
module i2c_addr_detect_chk (
  input logic       clk,
  input logic       rstN,
  input logic       startDet,
  input logic       stopDet,
  input logic       sclFall,
  input logic       sclRise,
  input logic       addrWe,
  input logic       txActive,
  input logic       txBit,
  input logic       sdaIn,
  input logic [6:0] localAddr,
  input logic       coinFlag,
  input logic       extFlag,
  input logic [2:0] extType,
  input logic       irqPulse,
  input logic       txErr
);

  // R5
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (coinFlag || extFlag));

  // R5
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  // R5
  irq_after_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(sclFall));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !addrWe |=> $stable(localAddr));

  // R9
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startDet || stopDet) |=> (!coinFlag && !extFlag && extType == 3'd0 && !txErr));

  // R11
  tx_mismatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txActive && sclRise && (txBit != sdaIn) && !startDet && !stopDet) |=> txErr);

endmodule

bind i2c_addr_detect i2c_addr_detect_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .startDet  (startDet),
  .stopDet   (stopDet),
  .sclFall   (sclFall),
  .sclRise   (sclRise),
  .addrWe    (addrWe),
  .txActive  (txActive),
  .txBit     (txBit),
  .sdaIn     (sdaIn),
  .localAddr (localAddr),
  .coinFlag  (coinFlag),
  .extFlag   (extFlag),
  .extType   (extType),
  .irqPulse  (irqPulse),
  .txErr     (txErr)
);

// File: tb/i2c_addr_detect_bench.sv
module i2c_addr_detect_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startDet = 1'b0, stopDet = 1'b0, sclFall = 1'b0, sclRise = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       addrWe = 1'b0;
  logic [6:0] addrWd = 7'h00;
  logic       relCmd = 1'b0, txActive = 1'b0, txBit = 1'b0, sdaIn = 1'b0;
  logic [6:0] localAddr;
  logic       engaged, coinFlag, extFlag, irqPulse, txErr;
  logic [2:0] extType;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  i2c_addr_detect u_i2c_addr_detect (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .sclFall(sclFall), .sclRise(sclRise), .rxByte(rxByte), .addrWe(addrWe),
    .addrWd(addrWd), .relCmd(relCmd), .txActive(txActive), .txBit(txBit),
    .sdaIn(sdaIn), .localAddr(localAddr), .engaged(engaged), .coinFlag(coinFlag),
    .extFlag(extFlag), .extType(extType), .irqPulse(irqPulse), .txErr(txErr)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulseStart();
    @(negedge clk) startDet = 1'b1;
    @(negedge clk) startDet = 1'b0;
  endtask

  task automatic fallStrobe();
    sclFall = 1'b1;
    @(negedge clk) sclFall = 1'b0;
    @(negedge clk);
  endtask

  task automatic setLocal(input logic [6:0] a);
    @(negedge clk) begin addrWe = 1'b1; addrWd = a; end
    @(negedge clk) addrWe = 1'b0;
  endtask

  // full address phase; checks pulse timing, flags and class
  task automatic addrPhase(input logic [7:0] b, input bit expCoin, input bit expExt,
                           input int expType, input string tag);
    bit expIrq;
    expIrq = expCoin || expExt;
    rxByte = b;
    pulseStart();
    for (int i = 0; i < 7; i++) fallStrobe();
    check({tag, " R5 no early irq"}, irqPulse, 0);
    sclFall = 1'b1;
    @(negedge clk) sclFall = 1'b0;
    check({tag, " R5 irq"}, irqPulse, expIrq);
    check({tag, " R2 coin"}, coinFlag, expCoin);
    check({tag, " R3 ext"}, extFlag, expExt);
    check({tag, " R4 type"}, extType, expType);
    @(negedge clk);
    check({tag, " R5 irq one cycle"}, irqPulse, 0);
    if (!expIrq) check({tag, " R6 disengaged"}, engaged, 0);
  endtask

  task automatic testReset();
    check("R1 coin", coinFlag, 0);
    check("R1 ext", extFlag, 0);
    check("R1 type", extType, 0);
    check("R1 irq", irqPulse, 0);
    check("R1 txErr", txErr, 0);
    check("R1 engaged", engaged, 0);
    check("R1 localAddr", localAddr, 0);
  endtask

  task automatic testClasses();
    setLocal(7'h28);
    addrPhase(8'h50, 1, 0, 0, "match");
    addrPhase(8'h52, 0, 0, 0, "nearmiss");
    addrPhase(8'h00, 0, 1, 1, "gcall");
    addrPhase(8'h01, 0, 1, 2, "startbyte");
    addrPhase(8'h02, 0, 1, 3, "cbus0");
    addrPhase(8'h03, 0, 1, 3, "cbus1");
    addrPhase(8'h05, 0, 1, 4, "otherbus");
    addrPhase(8'hF4, 0, 1, 5, "tenbit-nomatch");
    addrPhase(8'h06, 0, 1, 6, "rsvd-low");
    addrPhase(8'hF8, 0, 1, 6, "rsvd-high");
    // R7: extension codes left the local address alone
    check("R7 localAddr kept", localAddr, 7'h28);
  endtask

  task automatic testTenBit();
    setLocal(7'h79);
    addrPhase(8'hF2, 1, 1, 5, "R8 tenbit-match");
    check("R8 localAddr kept", localAddr, 7'h79);
  endtask

  task automatic testClear();
    setLocal(7'h28);
    addrPhase(8'h50, 1, 0, 0, "pre-stop");
    @(negedge clk) stopDet = 1'b1;
    @(negedge clk) stopDet = 1'b0;
    check("R9 stop clears coin", coinFlag, 0);
    check("R9 stop drops engaged", engaged, 0);
    addrPhase(8'h00, 0, 1, 1, "pre-start");
    pulseStart();
    check("R9 start clears ext", extFlag, 0);
    check("R9 start clears type", extType, 0);
  endtask

  task automatic testRelease();
    int irqSeen;
    irqSeen = 0;
    rxByte = 8'h50;
    pulseStart();
    for (int i = 0; i < 4; i++) fallStrobe();
    @(negedge clk) relCmd = 1'b1;
    @(negedge clk) relCmd = 1'b0;
    check("R10 engaged dropped", engaged, 0);
    for (int i = 0; i < 8; i++) begin
      sclFall = 1'b1;
      @(negedge clk) sclFall = 1'b0;
      if (irqPulse) irqSeen++;
      @(negedge clk);
      if (irqPulse) irqSeen++;
    end
    check("R10 no irq after release", irqSeen, 0);
    check("R10 no coin after release", coinFlag, 0);
  endtask

  task automatic txBitStep(input logic d, input logic s);
    @(negedge clk) begin txBit = d; sdaIn = s; sclRise = 1'b1; end
    @(negedge clk) sclRise = 1'b0;
  endtask

  task automatic testTxErr();
    pulseStart();
    txActive = 1'b1;
    txBitStep(1'b1, 1'b1);
    txBitStep(1'b0, 1'b0);
    check("R11 no error on agreement", txErr, 0);
    txBitStep(1'b1, 1'b0);
    check("R11 error on mismatch", txErr, 1);
    txBitStep(1'b0, 1'b0);
    check("R11 error sticky", txErr, 1);
    txActive = 1'b0;
    txBitStep(1'b1, 1'b0);
    pulseStart();
    check("R11 cleared by start", txErr, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClasses();
    testTenBit();
    testClear();
    testRelease();
    testTxErr();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule